// File: doc/BRIEF.md
# Debug-Mode Bus Grant Arbiter

This block decides when an external bus master may take over the address and data bus while the processor is halted under a serial debug port. An external master raises a request line. The arbiter answers with an acknowledge, but only when all of these hold: software has set the grant enable bit, debug mode is active, and the debug port is not in the middle of a transaction. If the serial shifter is idle when the request arrives, the grant is immediate. If the shifter is busy, the grant waits for a byte-separator bit of value 1, which marks the end of the current debug command. A separator of value 0 means that more reads or writes follow, so the request stays pending.

The request line is asynchronous and passes through a synchronizer before the arbiter samples it. Request and acknowledge form a four-phase handshake: the grant lasts until the request is withdrawn. While the bus is granted, any debug memory or I/O bus access is flagged as an error, because only debug-port and internal CPU registers are safe to reach at that time. Leaving debug mode while the bus is granted sets a sticky hazard bit. A small register port holds the enable bit and exposes a status word.

Top module: `dbg_bus_grant`

## Requirements
- R1: After reset the acknowledge is low, the control register (address 0) reads 0, and the status register (address 1) reads 0.
- R2: While the enable bit (control bit 0) is 0, a request is never acknowledged.
- R3: While the debug-mode input is low, no new grant is given.
- R4: With the enable bit set, debug mode active and the shifter idle, the acknowledge rises on the third rising clock edge after the request is raised (two synchronizer stages plus one arbiter register).
- R5: While the shifter is busy, a pending request is not granted, and separator strobes carrying 0 keep the acknowledge low.
- R6: A separator strobe carrying 1 while a request is pending raises the acknowledge at the next clock edge. A separator of 1 with no request pending has no effect.
- R7: Status bit 0 always equals the acknowledge output. Status bit 1 is 1 while a request waits for the end of a transaction.
- R8: A debug bus access while the acknowledge is high produces a one-cycle pulse on the error output and sets status bit 3. An access without a grant flags nothing. Writing 1 to status bit 3 clears it.
- R9: The acknowledge falls on the third rising clock edge after the request is withdrawn, and it stays high for as long as the synchronized request stays high.
- R10: If debug mode is low while the acknowledge is high, status bit 2 is set and stays set until 1 is written to status bit 2. Writing 1 to either status bit does not change the acknowledge.
- R11: Clearing the enable bit during a grant does not revoke it. It only blocks the next grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ext_req_i | input | 1 | Asynchronous external bus request |
| sep_valid_i | input | 1 | Strobe for a received byte-separator bit |
| sep_bit_i | input | 1 | Value of the separator bit |
| shift_busy_i | input | 1 | Serial shifter is moving data |
| dbg_mode_i | input | 1 | Processor is in debug mode |
| dbg_bus_access_i | input | 1 | Debug port starts a memory or I/O bus access |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address (0 control, 1 status) |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data for reg_addr_i |
| ext_ack_o | output | 1 | Bus acknowledge |
| acc_err_o | output | 1 | One-cycle pulse: bus access attempted during a grant |

## Verification
The checker assumes that the external master follows the four-phase handshake: it withdraws its request only while it holds the grant, or while no grant is being formed, and raises it again only after it has seen the acknowledge low. It also assumes that separator strobes come from the same clock domain as the arbiter. The stimulus keeps to these rules. Every request is held until its grant is checked, or until a fixed wait has shown that no grant comes. Each request is then dropped and the bench waits long enough for the synchronizer to drain. Separator strobes are one-cycle pulses driven between clock edges.

// File: rtl/dbg_bus_grant_pkg.sv
package dbg_bus_grant_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PEND  = 2'd1,
    ST_GRANT = 2'd2
  } grant_st_e;

  localparam int unsigned REG_CTRL   = 0;
  localparam int unsigned REG_STAT   = 1;
  localparam int unsigned CTRL_EN    = 0;
  localparam int unsigned STAT_ACK   = 0;
  localparam int unsigned STAT_PEND  = 1;
  localparam int unsigned STAT_HAZ   = 2;
  localparam int unsigned STAT_ERR   = 3;
  localparam int unsigned STAT_BITS  = 4;
endpackage

// File: rtl/dbg_req_sync.sv
module dbg_req_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[g] <= 1'b0;
          else         chain_q[g] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[g] <= 1'b0;
          else         chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/dbg_grant_fsm.sv
module dbg_grant_fsm
  import dbg_bus_grant_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic en_i,
  input  logic dbg_mode_i,
  input  logic shift_busy_i,
  input  logic sep_valid_i,
  input  logic sep_bit_i,
  output logic ack_o,
  output logic pend_o
);
  grant_st_e state_q, state_d;
  logic      may_grant;
  logic      op_done;

  // end of a debug command, or nothing in flight
  assign op_done   = !shift_busy_i || (sep_valid_i && sep_bit_i);
  assign may_grant = req_i && en_i && dbg_mode_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (may_grant) state_d = op_done ? ST_GRANT : ST_PEND;
      end
      ST_PEND: begin
        if (!may_grant)   state_d = ST_IDLE;
        else if (op_done) state_d = ST_GRANT;
      end
      ST_GRANT: begin
        // held until the request is withdrawn
        if (!req_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign ack_o  = (state_q == ST_GRANT);
  assign pend_o = (state_q == ST_PEND);
endmodule

// File: rtl/dbg_grant_regs.sv
module dbg_grant_regs
  import dbg_bus_grant_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ack_i,
  input  logic              pend_i,
  input  logic              dbg_mode_i,
  input  logic              bus_access_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              en_o,
  output logic              hazard_o,
  output logic              err_pulse_o
);
  logic en_q, haz_q, err_q, pulse_q;
  logic wr_ctrl, wr_stat;
  logic haz_set, err_set;
  logic [STAT_BITS-1:0] stat_w;

  assign wr_ctrl = wr_i && (addr_i == ADDR_W'(REG_CTRL));
  assign wr_stat = wr_i && (addr_i == ADDR_W'(REG_STAT));
  assign haz_set = ack_i && !dbg_mode_i;
  assign err_set = ack_i && bus_access_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      haz_q   <= 1'b0;
      err_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      if (wr_ctrl) en_q <= wdata_i[CTRL_EN];
      // set wins over a same-cycle clear
      haz_q   <= haz_set || (haz_q && !(wr_stat && wdata_i[STAT_HAZ]));
      err_q   <= err_set || (err_q && !(wr_stat && wdata_i[STAT_ERR]));
      pulse_q <= err_set;
    end
  end

  always_comb begin
    stat_w           = '0;
    stat_w[STAT_ACK]  = ack_i;
    stat_w[STAT_PEND] = pend_i;
    stat_w[STAT_HAZ]  = haz_q;
    stat_w[STAT_ERR]  = err_q;
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(REG_CTRL))      rdata_o[CTRL_EN] = en_q;
    else if (addr_i == ADDR_W'(REG_STAT)) rdata_o[STAT_BITS-1:0] = stat_w;
  end

  assign en_o        = en_q;
  assign hazard_o    = haz_q;
  assign err_pulse_o = pulse_q;
endmodule

// File: rtl/dbg_bus_grant.sv
module dbg_bus_grant
  import dbg_bus_grant_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned ADDR_W      = 1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_req_i,
  input  logic              sep_valid_i,
  input  logic              sep_bit_i,
  input  logic              shift_busy_i,
  input  logic              dbg_mode_i,
  input  logic              dbg_bus_access_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              ext_ack_o,
  output logic              acc_err_o
);
  logic req_sync;
  logic grant_en;
  logic grant_ack;
  logic grant_pend;
  logic hazard_sticky;

  dbg_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (ext_req_i),
    .q_o    (req_sync)
  );

  dbg_grant_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (req_sync),
    .en_i         (grant_en),
    .dbg_mode_i   (dbg_mode_i),
    .shift_busy_i (shift_busy_i),
    .sep_valid_i  (sep_valid_i),
    .sep_bit_i    (sep_bit_i),
    .ack_o        (grant_ack),
    .pend_o       (grant_pend)
  );

  dbg_grant_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (reg_wr_i),
    .addr_i       (reg_addr_i),
    .wdata_i      (reg_wdata_i),
    .ack_i        (grant_ack),
    .pend_i       (grant_pend),
    .dbg_mode_i   (dbg_mode_i),
    .bus_access_i (dbg_bus_access_i),
    .rdata_o      (reg_rdata_o),
    .en_o         (grant_en),
    .hazard_o     (hazard_sticky),
    .err_pulse_o  (acc_err_o)
  );

  assign ext_ack_o = grant_ack;
endmodule

// File: rtl/dbg_bus_grant_chk.sv
module dbg_bus_grant_chk
  import dbg_bus_grant_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_s_i,
  input logic              en_i,
  input logic              ack_i,
  input logic              busy_i,
  input logic              sep_valid_i,
  input logic              sep_bit_i,
  input logic              dbg_mode_i,
  input logic              bus_access_i,
  input logic              err_i,
  input logic              hazard_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] rdata_i
);
  a_r2_no_grant_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_i) |-> $past(en_i));

  a_r3_no_grant_outside_debug: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_i) |-> $past(dbg_mode_i));

  a_r5_r6_grant_at_op_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_i) |-> $past(!busy_i || (sep_valid_i && sep_bit_i)));

  a_r7_status_mirrors_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(REG_STAT)) |-> (rdata_i[STAT_ACK] == ack_i));

  a_r8_err_on_granted_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && bus_access_i) |=> err_i);

  a_r8_no_err_without_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_i) |-> $past(ack_i));

  a_r9_release_after_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !req_s_i) |=> !ack_i);

  a_r11_grant_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && req_s_i) |=> ack_i);

  a_r10_hazard_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !dbg_mode_i) |=> hazard_i);
endmodule

bind dbg_bus_grant dbg_bus_grant_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_s_i      (req_sync),
  .en_i         (grant_en),
  .ack_i        (ext_ack_o),
  .busy_i       (shift_busy_i),
  .sep_valid_i  (sep_valid_i),
  .sep_bit_i    (sep_bit_i),
  .dbg_mode_i   (dbg_mode_i),
  .bus_access_i (dbg_bus_access_i),
  .err_i        (acc_err_o),
  .hazard_i     (hazard_sticky),
  .addr_i       (reg_addr_i),
  .rdata_i      (reg_rdata_o)
);

// File: tb/dbg_bus_grant_tb.sv
module dbg_bus_grant_tb;
  localparam int DW = 8;
  localparam int AW = 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, sep_v = 1'b0, sep_b = 1'b0, busy = 1'b0;
  logic          dbg = 1'b0, acc = 1'b0, wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          ack, err;
  int            checks = 0, errors = 0;
  logic [DW-1:0] v;

  always #10 clk = ~clk;

  dbg_bus_grant #(.DATA_W(DW), .ADDR_W(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ext_req_i(req), .sep_valid_i(sep_v),
    .sep_bit_i(sep_b), .shift_busy_i(busy), .dbg_mode_i(dbg),
    .dbg_bus_access_i(acc), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .ext_ack_o(ack), .acc_err_o(err)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wreg(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr = 1'b1; addr = a; wdata = d;
    step(1);
    wr = 1'b0; wdata = '0;
  endtask

  initial begin
    #1ms;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1
    chk("R1 ack", {7'd0, ack}, 8'd0);
    rd(0, v); chk("R1 ctrl", v, 8'd0);
    rd(1, v); chk("R1 stat", v, 8'd0);

    // R2: disabled
    dbg = 1'b1; req = 1'b1;
    step(6); chk("R2 no ack", {7'd0, ack}, 8'd0);
    req = 1'b0; step(4);
    wreg(0, 8'h01);
    rd(0, v); chk("R2 ctrl en", v, 8'h01);

    // R3: outside debug mode
    dbg = 1'b0; req = 1'b1;
    step(6); chk("R3 no ack", {7'd0, ack}, 8'd0);
    req = 1'b0; step(4); dbg = 1'b1;

    // R4 idle grant latency, R9 release latency, R7 status
    req = 1'b1;
    step(2); chk("R4 not yet", {7'd0, ack}, 8'd0);
    step(1); chk("R4 ack", {7'd0, ack}, 8'd1);
    rd(1, v); chk("R7 stat ack", v, 8'h01);
    req = 1'b0;
    step(2); chk("R9 still", {7'd0, ack}, 8'd1);
    step(1); chk("R9 released", {7'd0, ack}, 8'd0);
    step(2);

    // R5/R6 sweep over number of zero separators
    for (int nz = 0; nz < 4; nz++) begin
      busy = 1'b1; req = 1'b1;
      step(3); chk("R5 pend no ack", {7'd0, ack}, 8'd0);
      rd(1, v); chk("R7 stat pend", v, 8'h02);
      for (int i = 0; i < nz; i++) begin
        sep_v = 1'b1; sep_b = 1'b0; step(1); sep_v = 1'b0;
        chk("R5 sep0", {7'd0, ack}, 8'd0);
        step(1); chk("R5 sep0 hold", {7'd0, ack}, 8'd0);
      end
      sep_v = 1'b1; sep_b = 1'b1; step(1); sep_v = 1'b0; sep_b = 1'b0;
      chk("R6 sep1 grant", {7'd0, ack}, 8'd1);
      busy = 1'b0; req = 1'b0;
      step(3); chk("R9 drop", {7'd0, ack}, 8'd0);
      step(2);
    end

    // R6: separator 1 with no request
    busy = 1'b1;
    sep_v = 1'b1; sep_b = 1'b1; step(1); sep_v = 1'b0; sep_b = 1'b0;
    step(1); chk("R6 sep1 no req", {7'd0, ack}, 8'd0);
    busy = 1'b0;

    // R8: access without grant
    acc = 1'b1; step(1); acc = 1'b0;
    chk("R8 no err", {7'd0, err}, 8'd0);
    rd(1, v); chk("R8 stat clean", v, 8'd0);
    // R8: access during grant
    req = 1'b1; step(3); chk("R8 grant", {7'd0, ack}, 8'd1);
    acc = 1'b1; step(1); acc = 1'b0;
    chk("R8 err pulse", {7'd0, err}, 8'd1);
    step(1); chk("R8 pulse ends", {7'd0, err}, 8'd0);
    rd(1, v); chk("R8 sticky", v, 8'h09);
    wreg(1, 8'h08);
    rd(1, v); chk("R8 cleared", v, 8'h01);

    // R10: hazard
    dbg = 1'b0; step(1); dbg = 1'b1;
    rd(1, v); chk("R10 hazard set", v, 8'h05);
    step(2);
    rd(1, v); chk("R10 hazard sticky", v, 8'h05);
    wreg(1, 8'h04);
    rd(1, v); chk("R10 hazard clear keeps ack", v, 8'h01);

    // R11: disable during grant
    wreg(0, 8'h00);
    step(4); chk("R11 grant held", {7'd0, ack}, 8'd1);
    req = 1'b0; step(3); chk("R11 release", {7'd0, ack}, 8'd0);
    step(2);
    req = 1'b1; step(6); chk("R11 new blocked", {7'd0, ack}, 8'd0);
    req = 1'b0; step(4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule